// File: doc/BRIEF.md
# DMA Beat Address Generator

This block produces the per-beat source and destination byte addresses for one block transfer of a descriptor-driven DMA channel. A start pulse captures two base addresses, a beat count and a set of configuration fields: per-address increment enables, a step-select bit, a 3-bit step code and a 2-bit beat-size code. Each beat-done handshake from the bus side then advances the enabled addresses and decrements the remaining beat count.

Each address is either held fixed or advanced by one beat's width in bytes. The step-select bit chooses the one address whose advance is multiplied by two raised to the step code. The other address advances by a single beat. The beat size is reported with every access and applies to both the read and the write side. When the last beat completes, the block raises a one-cycle completion flag and returns to idle. A start with an illegal size code or a zero count is refused and flagged.

Top module: `dma_beat_addr_gen`

## Requirements
- R1: A start pulse while idle with a legal configuration loads `src_addr` from `src_base`, `dst_addr` from `dst_base`, the remaining count from `beat_count` and `xfer_size` from `cfg_beat_size`, and raises `busy` one cycle later.
- R2: While busy with `cfg_src_inc` latched at 0, `src_addr` keeps the value it was loaded with for the whole block.
- R3: While busy with `cfg_dst_inc` latched at 0, `dst_addr` keeps the value it was loaded with for the whole block.
- R4: The beat-size code means 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. An enabled address that is not step-selected advances by that byte count on each beat-done, and `xfer_size` presents the latched code for the whole block.
- R5: When `cfg_step_on_src` is 1, an enabled source address advances by (beat bytes << `cfg_step_code`) per beat and the destination advances by the beat bytes. When it is 0, the roles are swapped.
- R6: The beat-done that takes the remaining count from 1 to 0 makes `block_done` high for exactly one cycle, in the cycle after that handshake. `busy` falls in the same cycle.
- R7: A start while idle with `cfg_beat_size` = 3 or `beat_count` = 0 is refused. `busy` stays low, the addresses do not change and `cfg_err` rises one cycle later. `cfg_err` stays high until the next accepted start clears it.
- R8: A start while busy is ignored, and so is a beat-done while idle. Neither changes the addresses, the count or the flags.
- R9: Addresses wrap modulo 2^ADDR_W.
- R10: After a synchronous reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block (one-cycle pulse) |
| cfg_src_inc | input | 1 | Source address advances per beat when 1 |
| cfg_dst_inc | input | 1 | Destination address advances per beat when 1 |
| cfg_step_on_src | input | 1 | Step multiplier applies to source (1) or destination (0) |
| cfg_step_code | input | STEP_W | Step multiplier exponent |
| cfg_beat_size | input | 2 | Beat width code (0 byte, 1 half word, 2 word, 3 illegal) |
| src_base | input | ADDR_W | Initial source address |
| dst_base | input | ADDR_W | Initial destination address |
| beat_count | input | CNT_W | Number of beats in the block |
| beat_done | input | 1 | Bus side completed one beat |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |
| xfer_size | output | 2 | Beat width code for both accesses |
| busy | output | 1 | Block in progress |
| block_done | output | 1 | One-cycle pulse after the final beat |
| cfg_err | output | 1 | Last start was refused |

## Verification
The bench builds the block with ADDR_W at its default of 32 and narrows CNT_W to 4. With that counter, the largest possible beat count of 15 fits in a short run, and the full-scale count is exercised alongside the one-beat and refused-zero cases. Keeping 32-bit addresses with the largest step code (a 512-byte advance for word beats) lets a block started near the top of the address space wrap through zero within a few beats.

// File: rtl/dbag_pkg.sv
package dbag_pkg;
  typedef enum logic [1:0] {
    BSZ_8   = 2'd0,
    BSZ_16  = 2'd1,
    BSZ_32  = 2'd2,
    BSZ_BAD = 2'd3
  } beat_size_e;

  localparam int NUM_CH = 2;
  localparam int CH_SRC = 0;
  localparam int CH_DST = 1;
endpackage

// File: rtl/dbag_step_calc.sv
module dbag_step_calc #(
  parameter int ADDR_W = 32,
  parameter int STEP_W = 3
) (
  input  logic              inc_en,
  input  logic              use_step,
  input  logic [1:0]        size_code,
  input  logic [STEP_W-1:0] step_code,
  output logic [ADDR_W-1:0] step
);
  logic [ADDR_W-1:0] unit;

  always_comb begin
    unit = ADDR_W'(1) << size_code;
    if (!inc_en)
      step = '0;
    else if (use_step)
      step = unit << step_code;
    else
      step = unit;
  end
endmodule

// File: rtl/dbag_addr_reg.sv
module dbag_addr_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              adv,
  input  logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)
      addr <= '0;
    else if (load)
      addr <= base;
    else if (adv)
      addr <= addr + step;
  end

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(addr));
endmodule

// File: rtl/dbag_beat_ctr.sv
module dbag_beat_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (load)
      remain <= cnt_in;
    else if (dec)
      remain <= remain - 1'b1;
  end

  assign last = (remain == CNT_W'(1));

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    dec |-> (remain != '0));
endmodule

// File: rtl/dma_beat_addr_gen.sv
module dma_beat_addr_gen
  import dbag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cfg_src_inc,
  input  logic              cfg_dst_inc,
  input  logic              cfg_step_on_src,
  input  logic [STEP_W-1:0] cfg_step_code,
  input  logic [1:0]        cfg_beat_size,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [CNT_W-1:0]  beat_count,
  input  logic              beat_done,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [1:0]        xfer_size,
  output logic              busy,
  output logic              block_done,
  output logic              cfg_err
);
  logic              busy_q, done_q, err_q;
  logic [1:0]        size_q;
  logic              src_inc_q, dst_inc_q, sel_q;
  logic [STEP_W-1:0] code_q;
  logic              cfg_ok, accept, refuse, beat, last;

  logic [NUM_CH-1:0]              inc_vec;
  logic [NUM_CH-1:0]              use_vec;
  logic [NUM_CH-1:0][ADDR_W-1:0]  base_vec;
  logic [NUM_CH-1:0][ADDR_W-1:0]  step_vec;
  logic [NUM_CH-1:0][ADDR_W-1:0]  addr_vec;

  assign cfg_ok = (cfg_beat_size != BSZ_BAD) && (beat_count != '0);
  assign accept = start && !busy_q && cfg_ok;
  assign refuse = start && !busy_q && !cfg_ok;
  assign beat   = beat_done && busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      size_q    <= '0;
      src_inc_q <= 1'b0;
      dst_inc_q <= 1'b0;
      sel_q     <= 1'b0;
      code_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q    <= 1'b1;
        err_q     <= 1'b0;
        size_q    <= cfg_beat_size;
        src_inc_q <= cfg_src_inc;
        dst_inc_q <= cfg_dst_inc;
        sel_q     <= cfg_step_on_src;
        code_q    <= cfg_step_code;
      end else if (refuse) begin
        err_q <= 1'b1;
      end else if (beat && last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign inc_vec[CH_SRC]  = src_inc_q;
  assign inc_vec[CH_DST]  = dst_inc_q;
  assign use_vec[CH_SRC]  = sel_q;
  assign use_vec[CH_DST]  = !sel_q;
  assign base_vec[CH_SRC] = src_base;
  assign base_vec[CH_DST] = dst_base;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    dbag_step_calc #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_step (
      .inc_en    (inc_vec[ch]),
      .use_step  (use_vec[ch]),
      .size_code (size_q),
      .step_code (code_q),
      .step      (step_vec[ch])
    );
    dbag_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
      .clk  (clk),
      .rst  (rst),
      .load (accept),
      .base (base_vec[ch]),
      .adv  (beat),
      .step (step_vec[ch]),
      .addr (addr_vec[ch])
    );
  end

  dbag_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .cnt_in (beat_count),
    .dec    (beat),
    .last   (last)
  );

  assign src_addr   = addr_vec[CH_SRC];
  assign dst_addr   = addr_vec[CH_DST];
  assign xfer_size  = size_q;
  assign busy       = busy_q;
  assign block_done = done_q;
  assign cfg_err    = err_q;

  assert_src_fixed_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !src_inc_q) |=> $stable(src_addr));
  assert_dst_fixed_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !dst_inc_q) |=> $stable(dst_addr));
  assert_size_legal_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (xfer_size != BSZ_BAD));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    block_done |=> !block_done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    block_done |-> !busy);
  assert_refuse_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_err) |-> !busy);
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !beat_done) |=> busy);
endmodule

// File: tb/tb_dma_beat_addr_gen.sv
`timescale 1ns/1ps
module tb_dma_beat_addr_gen;
  localparam int AW = 32;
  localparam int CW = 4;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, s_inc = 1'b0, d_inc = 1'b0, sel = 1'b0, bdone = 1'b0;
  logic [SW-1:0] code = '0;
  logic [1:0] bsz = '0;
  logic [AW-1:0] sbase = '0, dbase = '0;
  logic [CW-1:0] cnt = '0;
  logic [AW-1:0] src_addr, dst_addr;
  logic [1:0] xfer_size;
  logic busy, block_done, cfg_err;

  always #2.5 clk = ~clk;

  dma_beat_addr_gen #(.ADDR_W(AW), .CNT_W(CW), .STEP_W(SW)) dut (
    .clk(clk), .rst(rst), .start(start), .cfg_src_inc(s_inc), .cfg_dst_inc(d_inc),
    .cfg_step_on_src(sel), .cfg_step_code(code), .cfg_beat_size(bsz),
    .src_base(sbase), .dst_base(dbase), .beat_count(cnt), .beat_done(bdone),
    .src_addr(src_addr), .dst_addr(dst_addr), .xfer_size(xfer_size),
    .busy(busy), .block_done(block_done), .cfg_err(cfg_err));

  // reference model
  logic [AW-1:0] m_src = '0, m_dst = '0;
  int m_rem = 0;
  bit m_busy = 0, m_done = 0, m_err = 0;
  logic [1:0] m_size = '0;
  bit l_sinc = 0, l_dinc = 0, l_sel = 0;
  int l_code = 0;

  int tests = 0, fails = 0;
  bit finished = 0;
  string cur_req = "R10";

  always @(posedge clk) begin
    logic [AW-1:0] unit, ss, ds;
    if (rst) begin
      m_src = '0; m_dst = '0; m_rem = 0; m_busy = 0; m_done = 0; m_err = 0; m_size = '0;
      l_sinc = 0; l_dinc = 0; l_sel = 0; l_code = 0;
    end else begin
      m_done = 0;
      if (start && !m_busy) begin
        if (bsz == 2'd3 || cnt == 0) m_err = 1;
        else begin
          m_err = 0; m_src = sbase; m_dst = dbase; m_rem = int'(cnt); m_busy = 1;
          m_size = bsz; l_sinc = s_inc; l_dinc = d_inc; l_sel = sel; l_code = int'(code);
        end
      end else if (bdone && m_busy) begin
        unit = AW'(1) << m_size;
        ss = l_sinc ? (l_sel ? unit << l_code : unit) : '0;
        ds = l_dinc ? (!l_sel ? unit << l_code : unit) : '0;
        m_src = m_src + ss;
        m_dst = m_dst + ds;
        m_rem--;
        if (m_rem == 0) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      tests++;
      if (src_addr !== m_src || dst_addr !== m_dst || xfer_size !== m_size ||
          busy !== m_busy || block_done !== m_done || cfg_err !== m_err) begin
        fails++;
        $display("FAIL %s: got src=%h dst=%h sz=%0d busy=%b done=%b err=%b exp src=%h dst=%h sz=%0d busy=%b done=%b err=%b",
                 cur_req, src_addr, dst_addr, xfer_size, busy, block_done, cfg_err,
                 m_src, m_dst, m_size, m_busy, m_done, m_err);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic run_block(input string req, input bit si, input bit di, input bit sl,
                           input int cd, input int bs, input logic [AW-1:0] sb,
                           input logic [AW-1:0] db, input int n, input bit gaps);
    cur_req = req;
    s_inc = si; d_inc = di; sel = sl; code = SW'(cd); bsz = 2'(bs);
    sbase = sb; dbase = db; cnt = CW'(n); start = 1'b1;
    tick();
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 2 == 1)) begin bdone = 1'b0; tick(); end
      bdone = 1'b1; tick();
    end
    bdone = 1'b0;
    tick(); tick();
  endtask

  initial begin
    #200000;
    if (!finished) begin
      finished = 1; tests++; fails++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cur_req = "R10";
    tick(); tick(); tick();
    rst = 1'b0;
    tick();
    run_block("R1", 1, 1, 0, 0, 0, 32'h1000, 32'h2000, 3, 0);
    run_block("R4", 1, 1, 0, 0, 1, 32'h1100, 32'h2100, 4, 0);
    run_block("R4", 1, 1, 1, 0, 2, 32'h1200, 32'h2200, 5, 1);
    run_block("R5", 1, 1, 1, 3, 2, 32'h3000, 32'h4000, 4, 0);
    run_block("R5", 1, 1, 0, 2, 1, 32'h3000, 32'h4000, 6, 1);
    run_block("R2", 0, 1, 1, 5, 0, 32'h5000, 32'h6000, 4, 0);
    run_block("R3", 1, 0, 0, 4, 2, 32'h7000, 32'h8000, 4, 1);
    run_block("R6", 1, 1, 0, 1, 0, 32'h10, 32'h20, 1, 0);
    run_block("R6", 1, 1, 1, 7, 2, 32'h0, 32'h100, 15, 0);
    run_block("R9", 1, 1, 1, 7, 2, 32'hFFFF_FF00, 32'hFFFF_FFFC, 6, 0);
    // refused starts
    cur_req = "R7";
    bsz = 2'd3; cnt = 4'd3; sbase = 32'hDEAD_0000; start = 1'b1; tick();
    start = 1'b0; tick(); tick();
    bsz = 2'd0; cnt = 4'd0; start = 1'b1; tick();
    start = 1'b0; tick();
    bdone = 1'b1; tick(); bdone = 1'b0; tick();
    run_block("R7", 1, 1, 0, 0, 2, 32'h9000, 32'hA000, 2, 0);
    // start during busy and beat_done while idle
    cur_req = "R8";
    bdone = 1'b1; tick(); tick(); bdone = 1'b0; tick();
    s_inc = 1; d_inc = 1; sel = 0; code = 3'd1; bsz = 2'd1;
    sbase = 32'hB000; dbase = 32'hC000; cnt = 4'd4; start = 1'b1; tick();
    start = 1'b0; bdone = 1'b1; tick();
    sbase = 32'hEEEE_0000; dbase = 32'hFFFF_0000; cnt = 4'd9; bsz = 2'd3; start = 1'b1;
    tick(); start = 1'b0; tick(); tick(); bdone = 1'b0; tick(); tick();
    // reset mid-block
    cur_req = "R10";
    run_block("R1", 1, 1, 0, 0, 0, 32'h44, 32'h88, 2, 0);
    cur_req = "R10";
    start = 1'b1; cnt = 4'd5; tick(); start = 1'b0; bdone = 1'b1; tick();
    rst = 1'b1; tick(); bdone = 1'b0; tick(); rst = 1'b0; tick(); tick();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule